// File: doc/BRIEF.md
# I2C Target Controller with Cause-Coded Interrupt

This block is a byte-level I2C target for a host processor. It watches the two bus lines and finds start, repeated start and stop conditions. It compares each address byte with a 7-bit own address and with the general call address, and answers a match with an acknowledge. It then receives data bytes into a host-readable register or sends bytes from a host-written register. One interrupt line tells the host that something happened. A 2-bit cause field says what it was: a fresh start with a matching address, a repeated start with a matching address, a finished data byte, or a stop that closes an addressed transfer.

A mode bit takes the hardware target off the bus and hands both lines to software. Register bits then drive the clock line and the data line directly, and a further bit captures the data line on each rising clock edge, so firmware can bit-bang a controller. Both lines are open-drain. The outputs are pull-low enables: a 1 pulls the line to ground and a 0 releases it. The line inputs pass through a two-stage synchronizer before any logic uses them.

Top module: `i2ct_top`

## Requirements
- R1: After reset, reading any of the four registers returns 0x00. The interrupt line is low and both pull-low enables are 0.
- R2: An address byte whose upper seven bits equal `own_addr` is acknowledged: the target pulls the data line low during the ninth clock. The interrupt is raised, and the cause field (control bits 5:4) reads 00 after a start.
- R3: An address byte that matches neither the own address nor the general call address is not acknowledged and raises no interrupt.
- R4: A matching address that follows a repeated start (a start with no stop since the previous start) sets the cause field to 01.
- R5: In a write transfer, each received byte is acknowledged, can be read at register address 3, and sets the cause field to 10.
- R6: In a read transfer, the byte in register address 2 is loaded on the address match and again after each byte the controller acknowledges. It is shifted out MSB first, and each byte sets the cause field to 10. A not-acknowledge releases the data line until the next start.
- R7: A stop after a matched address sets the cause field to 11 and raises the interrupt. This happens only while the stop-enable bit (control bit 1) is 1. With that bit at 0, a stop raises no interrupt.
- R8: Address 0x00 with the write direction is the general call. It is acknowledged and sets the general-call flag (control bit 2). The flag stays set until the host writes 0 to that bit. Writing 1 to it leaves it unchanged.
- R9: The pending bit (control bit 3) drives the interrupt line. It stays set until the host writes 1 to it. A new event that arrives while it is pending overwrites the cause field.
- R10: With the mode bit (control bit 0) at 1, the hardware target ignores the bus. The clock line is pulled low exactly when pin-register bit 0 is 0. The data line is pulled low exactly when pin-register bit 2 (output enable) is 1 and bit 1 (output value) is 0.
- R11: In software mode, pin-register bit 3 takes the synchronized data line on each rising clock-line edge while bit 2 is 0. At any other time it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 pins, 2 transmit byte, 3 received byte |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data of the selected register |
| own_addr | input | 7 | Own 7-bit target address |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe_o | output | 1 | Pull clock line low |
| sda_oe_o | output | 1 | Pull data line low |
| irq_o | output | 1 | Interrupt, high while an event is pending |

## Verification
Some properties are checked on every cycle. The pending interrupt and the general-call flag hold until the host clears them. A stop always releases the data line. A stop cause only appears when stops are enabled. The engine never drives while software owns the pins. The sampled data bit changes only on a rising clock edge.

Other behaviour can only be shown by directed bus scenarios. These cover the value of each cause code, the acknowledge on the ninth clock, the bytes exchanged in both directions, the reload of the transmit byte after a controller acknowledge, the release after a not-acknowledge, and the silence of the target on a foreign address or in software mode.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W = 8;
    localparam int ADR_W  = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    // interrupt cause codes
    localparam logic [1:0] CAUSE_START  = 2'b00;
    localparam logic [1:0] CAUSE_RSTART = 2'b01;
    localparam logic [1:0] CAUSE_DATA   = 2'b10;
    localparam logic [1:0] CAUSE_STOP   = 2'b11;

    // host register selects
    localparam logic [1:0] RSEL_CTL = 2'd0;
    localparam logic [1:0] RSEL_PIN = 2'd1;
    localparam logic [1:0] RSEL_TX  = 2'd2;
    localparam logic [1:0] RSEL_RX  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_WAIT
    } eng_st_e;

    typedef struct packed {
        eng_st_e            st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic               rw;
        logic               ack_ph;
        logic               mack;
        logic               busy;
        logic               rep;
        logic               addressed;
        logic               drv;
        logic               evt;
        logic [1:0]         code;
        logic               gc;
        logic [BYTE_W-1:0]  rx;
    } eng_s_t;

    typedef struct packed {
        logic               sw_mode;
        logic               stop_ie;
        logic               gc;
        logic               irq;
        logic [1:0]         code;
        logic               pin_scl;
        logic               pin_sdo;
        logic               pin_sdoe;
        logic               sdain;
        logic [BYTE_W-1:0]  tx;
    } regs_s_t;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stg_d;
        if (g == 0) begin : g_first
            assign stg_d = async_i;
        end else begin : g_next
            assign stg_d = stg_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '1;
            else        stg_q[g] <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    // data edges while the clock stays high are bus conditions
    assign start_o = prev_q.scl & scl_s & prev_q.sda & ~sda_s;
    assign stop_o  = prev_q.scl & scl_s & ~prev_q.sda & sda_s;
    assign rise_o  = ~prev_q.scl & scl_s;
    assign fall_o  = prev_q.scl & ~scl_s;

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sda_i,
    input  logic [ADR_W-1:0]  own_addr_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              stop_ie_i,
    output logic              sda_low_o,
    output logic              evt_o,
    output logic [1:0]        evt_code_o,
    output logic              gc_hit_o,
    output logic [BYTE_W-1:0] rx_byte_o
);

    eng_s_t d, q;
    logic   gc_m, own_m;

    assign gc_m  = (q.sh[ADR_W-1:0] == '0) && !sda_i;
    assign own_m = (q.sh[ADR_W-1:0] == own_addr_i);

    always_comb begin
        d     = q;
        d.evt = 1'b0;
        d.gc  = 1'b0;
        if (!en_i) begin
            d.st        = ST_IDLE;
            d.drv       = 1'b0;
            d.busy      = 1'b0;
            d.addressed = 1'b0;
            d.ack_ph    = 1'b0;
        end else if (start_i) begin
            d.st        = ST_ADDR;
            d.cnt       = '0;
            d.drv       = 1'b0;
            d.ack_ph    = 1'b0;
            d.addressed = 1'b0;
            d.rep       = q.busy;
            d.busy      = 1'b1;
        end else if (stop_i) begin
            d.st        = ST_IDLE;
            d.drv       = 1'b0;
            d.busy      = 1'b0;
            d.ack_ph    = 1'b0;
            d.addressed = 1'b0;
            if (q.addressed && stop_ie_i) begin
                d.evt  = 1'b1;
                d.code = CAUSE_STOP;
            end
        end else begin
            unique case (q.st)
                ST_ADDR: if (rise_i) begin
                    d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(BYTE_W-1)) begin
                        if (gc_m || own_m) begin
                            d.st        = ST_AACK;
                            d.ack_ph    = 1'b0;
                            d.addressed = 1'b1;
                            d.rw        = sda_i;
                            d.evt       = 1'b1;
                            d.code      = q.rep ? CAUSE_RSTART : CAUSE_START;
                            d.gc        = gc_m;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                ST_AACK, ST_RACK: if (fall_i) begin
                    if (!q.ack_ph) begin
                        d.drv    = 1'b1;
                        d.ack_ph = 1'b1;
                    end else begin
                        d.ack_ph = 1'b0;
                        d.cnt    = '0;
                        if (q.st == ST_AACK && q.rw) begin
                            d.st  = ST_TX;
                            d.sh  = tx_byte_i;
                            d.drv = ~tx_byte_i[BYTE_W-1];
                        end else begin
                            d.st  = ST_RX;
                            d.drv = 1'b0;
                        end
                    end
                end
                ST_RX: if (rise_i) begin
                    d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(BYTE_W-1)) begin
                        d.rx     = {q.sh[BYTE_W-2:0], sda_i};
                        d.st     = ST_RACK;
                        d.ack_ph = 1'b0;
                        d.evt    = 1'b1;
                        d.code   = CAUSE_DATA;
                    end
                end
                ST_TX: begin
                    if (rise_i) begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(BYTE_W-1)) begin
                            d.st     = ST_TACK;
                            d.ack_ph = 1'b0;
                            d.evt    = 1'b1;
                            d.code   = CAUSE_DATA;
                        end
                    end else if (fall_i && q.cnt != '0) begin
                        d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                        d.drv = ~q.sh[BYTE_W-2];
                    end
                end
                ST_TACK: begin
                    if (rise_i && q.ack_ph) begin
                        d.mack = sda_i;
                    end else if (fall_i) begin
                        if (!q.ack_ph) begin
                            d.drv    = 1'b0;
                            d.ack_ph = 1'b1;
                        end else if (!q.mack) begin
                            d.st     = ST_TX;
                            d.cnt    = '0;
                            d.ack_ph = 1'b0;
                            d.sh     = tx_byte_i;
                            d.drv    = ~tx_byte_i[BYTE_W-1];
                        end else begin
                            d.st     = ST_WAIT;
                            d.ack_ph = 1'b0;
                            d.drv    = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_low_o  = q.drv;
    assign evt_o      = q.evt;
    assign evt_code_o = q.code;
    assign gc_hit_o   = q.gc;
    assign rx_byte_o  = q.rx;

    // R7: a stop always frees the data line on the next cycle
    p_stop_frees_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && stop_i) |=> !sda_low_o);

    // R7: a stop cause is only reported when stops were enabled
    p_stop_evt_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && evt_code_o == CAUSE_STOP) |-> $past(stop_ie_i));

    // R3: the target only pulls the data line inside an addressed transfer
    p_drive_needs_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low_o |-> q.addressed);

endmodule

// File: rtl/i2ct_top.sv
module i2ct_top
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [6:0]  own_addr,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe_o,
    output logic        sda_oe_o,
    output logic        irq_o
);

    logic [1:0]        line_s;
    logic              scl_s, sda_s;
    logic              c_start, c_stop, c_rise, c_fall;
    logic              eng_low, eng_evt, eng_gc;
    logic [1:0]        eng_code;
    logic [BYTE_W-1:0] eng_rx;
    logic              wr_ctl, wr_pin, wr_tx;
    logic              unused_wbits;
    regs_s_t           d, q;

    i2ct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2ct_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_o (c_start),
        .stop_o  (c_stop),
        .rise_o  (c_rise),
        .fall_o  (c_fall)
    );

    i2ct_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (!q.sw_mode),
        .start_i    (c_start),
        .stop_i     (c_stop),
        .rise_i     (c_rise),
        .fall_i     (c_fall),
        .sda_i      (sda_s),
        .own_addr_i (own_addr),
        .tx_byte_i  (q.tx),
        .stop_ie_i  (q.stop_ie),
        .sda_low_o  (eng_low),
        .evt_o      (eng_evt),
        .evt_code_o (eng_code),
        .gc_hit_o   (eng_gc),
        .rx_byte_o  (eng_rx)
    );

    assign wr_ctl       = reg_wr && reg_addr == RSEL_CTL;
    assign wr_pin       = reg_wr && reg_addr == RSEL_PIN;
    assign wr_tx        = reg_wr && reg_addr == RSEL_TX;
    assign unused_wbits = ^reg_wdata[7:4];

    always_comb begin
        d = q;
        if (wr_ctl) begin
            d.sw_mode = reg_wdata[0];
            d.stop_ie = reg_wdata[1];
            if (!reg_wdata[2]) d.gc  = 1'b0;
            if (reg_wdata[3])  d.irq = 1'b0;
        end
        if (wr_pin) begin
            d.pin_scl  = reg_wdata[0];
            d.pin_sdo  = reg_wdata[1];
            d.pin_sdoe = reg_wdata[2];
        end
        if (wr_tx) d.tx = reg_wdata;
        // hardware events take priority over a host clear in the same cycle
        if (eng_evt) begin
            d.irq  = 1'b1;
            d.code = eng_code;
        end
        if (eng_gc) d.gc = 1'b1;
        if (q.sw_mode && c_rise && !q.pin_sdoe) d.sdain = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr)
            RSEL_CTL: reg_rdata = {2'b00, q.code, q.irq, q.gc, q.stop_ie, q.sw_mode};
            RSEL_PIN: reg_rdata = {4'b0000, q.sdain, q.pin_sdoe, q.pin_sdo, q.pin_scl};
            RSEL_TX:  reg_rdata = q.tx;
            default:  reg_rdata = eng_rx;
        endcase
    end

    assign scl_oe_o = q.sw_mode & ~q.pin_scl;
    assign sda_oe_o = q.sw_mode ? (q.pin_sdoe & ~q.pin_sdo) : eng_low;
    assign irq_o    = q.irq;

    // R9: a pending interrupt persists until the host writes 1 to clear it
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(wr_ctl && reg_wdata[3])) |=> irq_o);

    // R8: the general-call flag persists until the host writes 0 to it
    p_gc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.gc && !(wr_ctl && !reg_wdata[2])) |=> q.gc);

    // R10: the hardware target stays silent while software owns the pins
    p_hw_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sw_mode && $past(q.sw_mode)) |-> !eng_low);

    // R11: the sampled data bit only changes on a rising clock edge
    p_sdain_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !c_rise |=> $stable(q.sdain));

endmodule

// File: tb/i2ct_top_tb_top.sv
module i2ct_top_tb_top;

    localparam int HP = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [6:0] own_addr = 7'h2A;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_oe, sda_oe, irq;
    wire        scl_ln = scl_m & ~scl_oe;
    wire        sda_ln = sda_m & ~sda_oe;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    i2ct_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .own_addr  (own_addr),
        .scl_i     (scl_ln),
        .sda_i     (sda_ln),
        .scl_oe_o  (scl_oe),
        .sda_oe_o  (sda_oe),
        .irq_o     (irq)
    );

    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic b_start();
        sda_m = 1'b1; scl_m = 1'b1; hp();
        sda_m = 1'b0; hp();
        scl_m = 1'b0; hp();
    endtask

    task automatic b_rstart();
        sda_m = 1'b1; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b0; hp();
        scl_m = 1'b0; hp();
    endtask

    task automatic b_stop();
        sda_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp();
            scl_m = 1'b1; hp();
            scl_m = 1'b0; hp();
        end
        sda_m = 1'b1; hp();
        scl_m = 1'b1; hp();
        ack = sda_ln;
        scl_m = 1'b0; hp();
    endtask

    task automatic recv(input logic do_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            scl_m = 1'b1; hp();
            b = {b[6:0], sda_ln};
            scl_m = 1'b0; hp();
        end
        sda_m = do_ack ? 1'b0 : 1'b1; hp();
        scl_m = 1'b1; hp();
        scl_m = 1'b0; hp();
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register reset", v, 8'h00);
        end
        chk("R1 irq reset", irq, 0);
        chk("R1 scl release", scl_oe, 0);
        chk("R1 sda release", sda_oe, 0);
    endtask

    task automatic t_write();
        logic ack; logic [7:0] v;
        b_start();
        send(8'h54, ack);
        chk("R2 address ack", ack, 0);
        rd(2'd0, v);
        chk("R2 irq pending", v[3], 1);
        chk("R2 cause start", v[5:4], 2'b00);
        send(8'hC3, ack);
        chk("R5 data ack", ack, 0);
        rd(2'd3, v);
        chk("R5 rx byte", v, 8'hC3);
        rd(2'd0, v);
        chk("R5 cause data", v[5:4], 2'b10);
        wr(2'd0, 8'h0C);
        chk("R9 irq cleared", irq, 0);
        b_stop();
        chk("R7 no stop irq when disabled", irq, 0);
    endtask

    task automatic t_mismatch();
        logic ack;
        b_start();
        send(8'h22, ack);
        chk("R3 no ack", ack, 1);
        chk("R3 no irq", irq, 0);
        b_stop();
    endtask

    task automatic t_rstart();
        logic ack; logic [7:0] v;
        wr(2'd0, 8'h06);
        b_start();
        send(8'h54, ack);
        chk("R2 ack first start", ack, 0);
        wr(2'd0, 8'h0E);
        b_rstart();
        send(8'h54, ack);
        rd(2'd0, v);
        chk("R4 cause repeated start", v[5:4], 2'b01);
        b_stop();
        rd(2'd0, v);
        chk("R7 cause stop", v[5:4], 2'b11);
        chk("R9 still pending overwritten", v[3], 1);
        wr(2'd0, 8'h0E);
    endtask

    task automatic t_read();
        logic ack; logic [7:0] v, b;
        wr(2'd2, 8'hA5);
        b_start();
        send(8'h55, ack);
        chk("R6 read address ack", ack, 0);
        wr(2'd2, 8'h3C);
        recv(1'b1, b);
        chk("R6 first byte", b, 8'hA5);
        rd(2'd0, v);
        chk("R6 cause data", v[5:4], 2'b10);
        recv(1'b0, b);
        chk("R6 reloaded byte", b, 8'h3C);
        chk("R6 release after nack", sda_oe, 0);
        b_stop();
        rd(2'd0, v);
        chk("R7 stop after read", v[5:4], 2'b11);
        wr(2'd0, 8'h0E);
    endtask

    task automatic t_gcall();
        logic ack; logic [7:0] v;
        b_start();
        send(8'h00, ack);
        chk("R8 general call ack", ack, 0);
        rd(2'd0, v);
        chk("R8 gc flag set", v[2], 1);
        chk("R8 cause start", v[5:4], 2'b00);
        b_stop();
        wr(2'd0, 8'h0E);
        rd(2'd0, v);
        chk("R8 gc kept on write 1", v[2], 1);
        chk("R9 irq cleared by write 1", v[3], 0);
        wr(2'd0, 8'h0A);
        rd(2'd0, v);
        chk("R8 gc cleared on write 0", v[2], 0);
    endtask

    task automatic t_swmode();
        logic ack;
        wr(2'd0, 8'h01);
        chk("R10 scl pulled when bit 0", scl_oe, 1);
        wr(2'd1, 8'h01);
        chk("R10 scl released", scl_oe, 0);
        wr(2'd1, 8'h05);
        chk("R10 sda pulled oe1 out0", sda_oe, 1);
        wr(2'd1, 8'h07);
        chk("R10 sda released oe1 out1", sda_oe, 0);
        wr(2'd1, 8'h03);
        chk("R10 sda released oe0", sda_oe, 0);
        wr(2'd1, 8'h01);
        b_start();
        send(8'h54, ack);
        chk("R10 hardware ignores bus", ack, 1);
        chk("R10 no irq in sw mode", irq, 0);
        b_stop();
    endtask

    task automatic t_sample();
        logic [7:0] v;
        sda_m = 1'b0; scl_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        rd(2'd1, v);
        chk("R11 sampled low", v[3], 0);
        sda_m = 1'b1; hp();
        rd(2'd1, v);
        chk("R11 hold without edge", v[3], 0);
        scl_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        rd(2'd1, v);
        chk("R11 sampled high", v[3], 1);
        wr(2'd1, 8'h07);
        scl_m = 1'b0; hp();
        sda_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        rd(2'd1, v);
        chk("R11 no sample while oe", v[3], 1);
        sda_m = 1'b1; hp();
        wr(2'd0, 8'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_mismatch();
        t_rstart();
        t_read();
        t_gcall();
        t_swmode();
        t_sample();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule